// File: doc/BRIEF.md
# SPI Master Channel with Register Control

This block is one SPI master channel that software drives through six word-addressed registers. A configuration register selects clock polarity and phase, the word length, a power-of-two clock divisor, the chip-select polarity, the transfer direction and a bit that holds chip select active. A status register reports receive-full, transmit-empty and end-of-transfer. A control register enables the channel. Data moves through a transmit register and a receive register. A system register starts a soft reset and reports when that reset has finished.

Register map (word addresses): 0 configuration, 1 status, 2 control, 3 transmit data, 4 receive data, 5 system. Configuration fields are bit 0 CPHA, bit 1 CPOL, bits [5:2] divisor exponent, bit 6 chip-select polarity, bits [11:7] word length minus one, bits [13:12] transfer direction, and bit 20 chip-select hold. Unlisted bits read as zero. Words shift MSB first. The divisor reference runs at half the core clock, so SCLK toggles once every 2^d core cycles. Chip select changes only when software changes the hold bit. It never changes at word boundaries.

Top module: `spi_chan_master`

## Requirements
- R1: After reset the configuration reads 0x3C0 (8-bit words, active-low select, divisor 0, mode 0). Status reads 0x6 and the system register reads 1. SCLK is 0 and the chip-select pin is 1.
- R2: With divisor exponent d = conf[5:2], one SCLK period lasts 2^(d+1) core cycles. Exponents above 12 act as 12, which gives 8192 cycles per period.
- R3: conf[1] is the SCLK idle level. conf[0] = 0 samples MISO on the leading edge, and conf[0] = 1 samples it on the trailing edge. Data is exchanged MSB first correctly in all four modes.
- R4: conf[11:7] holds the word length minus one, up to 15 (16 bits). Values below 3 act as 3, which gives 4-bit words.
- R5: The chip-select pin is active while conf[20] is 1 and inactive while it is 0. The active level is low when conf[6] is 1 and high when conf[6] is 0. The pin stays active between words.
- R6: Status bit 0 is set when a received word lands and is cleared by a read of address 4. Status bit 1 (transmit empty) is cleared by a write to address 3 and set again when the word moves into the shifter. Status bit 2 is 1 when the shifter is idle and no transmit word is pending.
- R7: While control bit 0 is 0, no shifting takes place and SCLK rests at its idle level. A pending transmit word starts shifting once the bit is set to 1, and clearing the bit stops the channel.
- R8: In transmit-only mode (conf[13:12] = 10) words go out on MOSI and status bit 0 is never set.
- R9: In receive-only mode (conf[13:12] = 01) a single write to address 3 starts clocking. Each further word starts only after the previous word has been read, so the channel stalls while receive-full is set.
- R10: Writing 1 to system bit 0 holds every register at its default for 4 cycles. During that time system bit 0 reads 0, and afterwards it reads 1.
- R11: In transmit-and-receive mode (conf[13:12] = 00 or 11), a word written while a transfer is in progress is shifted back to back after it. Each word's received data is delivered in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register word address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects on receive data) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_pin | output | 1 | Chip select, polarity per configuration |

## Verification
The hardest behaviour to reach is the receive-only flow. There, one transmit write must produce an unbounded stream of words that advances only as fast as software drains the receive register. The bench withholds the first read for a long stretch and counts completed words at a slave model, to show that the channel stalls. It then reads three words in turn and clears the enable in the middle of the next word, which proves that the stream both restarts and stops. The slowest divisor is exercised with a 4-bit word whose length code is below the minimum, so that both clamps are covered in one transfer.

// File: rtl/spi_chan_master.sv
module spi_chan_master #(
  parameter int MAX_W    = 16,
  parameter int DIV_MAX  = 12,
  parameter int SRST_CYC = 4
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        cs_pin
);
  localparam int HCW = DIV_MAX + 1;
  localparam int ECW = $clog2(2 * MAX_W);
  localparam int IW  = $clog2(MAX_W);
  localparam int SCW = $clog2(SRST_CYC + 1);
  localparam logic [4:0] WL_TOP  = 5'(MAX_W - 1);
  localparam logic [3:0] DIV_TOP = 4'(DIV_MAX);
  localparam logic [2:0] A_CONF = 3'd0, A_STAT = 3'd1, A_CTRL = 3'd2,
                         A_TX = 3'd3, A_RX = 3'd4, A_SYS = 3'd5;

  logic             c_pha, c_pol, c_epol, c_force;
  logic [3:0]       c_div;
  logic [4:0]       c_wl;
  logic [1:0]       c_trm;
  logic             en, busy, sclk_r, armed;
  logic [MAX_W-1:0] tx_buf, rx_buf, tsh, rsh;
  logic             tx_full, rx_full;
  logic [HCW-1:0]   hcnt;
  logic [ECW-1:0]   ecnt;
  logic [SCW-1:0]   srst_cnt;

  wire wr_conf = bus_wr && bus_addr == A_CONF;
  wire wr_ctrl = bus_wr && bus_addr == A_CTRL;
  wire wr_tx   = bus_wr && bus_addr == A_TX;
  wire wr_sys  = bus_wr && bus_addr == A_SYS;
  wire rd_rx   = bus_rd && bus_addr == A_RX;

  wire srst_go  = (wr_sys && bus_wdata[0]) || (srst_cnt != '0);
  wire rst_done = (srst_cnt == '0);

  wire rx_mode = (c_trm == 2'b01);
  wire tx_mode = (c_trm == 2'b10);

  logic [4:0] wl_eff;
  logic [3:0] div_eff;
  assign wl_eff  = (c_wl < 5'd3) ? 5'd3 : ((c_wl > WL_TOP) ? WL_TOP : c_wl);
  assign div_eff = (c_div > DIV_TOP) ? DIV_TOP : c_div;

  logic [HCW-1:0] half_lim;
  assign half_lim = (HCW'(1) << div_eff) - HCW'(1);

  wire tick      = (hcnt == half_lim);
  wire leading   = ~ecnt[0];
  wire samp      = leading ^ c_pha;
  wire shift_ev  = ~samp && !(c_pha && ecnt == '0);
  wire last_edge = (int'(ecnt) == 2 * int'(wl_eff) + 1);
  wire start     = en && !busy &&
                   (rx_mode ? ((tx_full || armed) && !rx_full) : tx_full);

  logic [MAX_W-1:0] rsh_next;
  assign rsh_next = {rsh[MAX_W-2:0], miso};

  always_ff @(posedge clk) begin
    if (!rst_n) srst_cnt <= '0;
    else if (wr_sys && bus_wdata[0]) srst_cnt <= SCW'(SRST_CYC);
    else if (srst_cnt != '0) srst_cnt <= srst_cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || srst_go) begin
      c_pha   <= 1'b0;
      c_pol   <= 1'b0;
      c_div   <= 4'd0;
      c_epol  <= 1'b1;
      c_wl    <= 5'd7;
      c_trm   <= 2'b00;
      c_force <= 1'b0;
      en      <= 1'b0;
      busy    <= 1'b0;
      sclk_r  <= 1'b0;
      armed   <= 1'b0;
      tx_buf  <= '0;
      rx_buf  <= '0;
      tsh     <= '0;
      rsh     <= '0;
      tx_full <= 1'b0;
      rx_full <= 1'b0;
      hcnt    <= '0;
      ecnt    <= '0;
    end else begin
      if (wr_conf) begin
        c_pha   <= bus_wdata[0];
        c_pol   <= bus_wdata[1];
        c_div   <= bus_wdata[5:2];
        c_epol  <= bus_wdata[6];
        c_wl    <= bus_wdata[11:7];
        c_trm   <= bus_wdata[13:12];
        c_force <= bus_wdata[20];
      end
      if (wr_ctrl) en <= bus_wdata[0];
      if (!rx_mode || !en) armed <= 1'b0;
      if (rd_rx) rx_full <= 1'b0;

      if (!en) begin
        busy   <= 1'b0;
        sclk_r <= c_pol;
      end else if (!busy) begin
        sclk_r <= c_pol;
        if (start) begin
          busy    <= 1'b1;
          hcnt    <= '0;
          ecnt    <= '0;
          tsh     <= tx_full ? tx_buf : '0;
          tx_full <= 1'b0;
          rsh     <= '0;
          if (rx_mode) armed <= 1'b1;
        end
      end else if (tick) begin
        hcnt   <= '0;
        sclk_r <= ~sclk_r;
        ecnt   <= ecnt + 1'b1;
        if (samp) rsh <= rsh_next;
        if (shift_ev) tsh <= tsh << 1;
        if (last_edge) begin
          busy <= 1'b0;
          if (!tx_mode) begin
            rx_buf  <= samp ? rsh_next : rsh;
            rx_full <= 1'b1;
          end
        end
      end else begin
        hcnt <= hcnt + 1'b1;
      end

      if (wr_tx) begin
        tx_buf  <= bus_wdata[MAX_W-1:0];
        tx_full <= 1'b1;
      end
    end
  end

  assign sclk   = sclk_r;
  assign mosi   = tsh[wl_eff[IW-1:0]];
  assign cs_pin = c_force ^ c_epol;

  always_comb begin
    case (bus_addr)
      A_CONF:  bus_rdata = {11'b0, c_force, 6'b0, c_trm, c_wl, c_epol, c_div, c_pol, c_pha};
      A_STAT:  bus_rdata = {29'b0, !busy && !tx_full, !tx_full, rx_full};
      A_CTRL:  bus_rdata = {31'b0, en};
      A_RX:    bus_rdata = {{(32-MAX_W){1'b0}}, rx_buf};
      A_SYS:   bus_rdata = {31'b0, rst_done};
      default: bus_rdata = 32'b0;
    endcase
  end

  a_r3_sclk_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !srst_go) |=> (sclk == $past(c_pol)));

  a_r8_txonly_no_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_mode && !rx_full) |=> !rx_full);

  a_r9_rx_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_mode && rx_full && !busy) |=> !busy);

  a_r10_reset_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sys && bus_wdata[0]) |=> (bus_addr != A_SYS || bus_rdata[0] == 1'b0) && !rst_done);

  a_r6_tx_write_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tx && srst_cnt == '0) |=> tx_full);

  a_r7_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !srst_go) |=> !busy);
endmodule

// File: tb/spi_chan_master_tb.sv
`timescale 1ns/1ps
module spi_chan_master_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sclk, mosi, cs_pin;
  logic        miso = 1'b0;

  spi_chan_master u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_pin(cs_pin));

  int n_tests = 0, n_fail = 0, cyc = 0, tog = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // slave model and scoreboard monitor
  logic [15:0] resp_q[$];
  logic [15:0] exp_q[$];
  logic [15:0] s_tx = '0, s_rx = '0;
  int  s_n = 8, s_idx = 0, s_words = 0;
  bit  s_cpol = 0, s_cpha = 0, s_on = 0, mon_on = 0;

  task automatic slave_start(input int n, input bit pol, input bit pha);
    s_n = n; s_cpol = pol; s_cpha = pha; s_idx = 0; s_rx = '0; s_words = 0;
    s_tx = (resp_q.size() > 0) ? resp_q.pop_front() : 16'h0;
    miso = s_tx[n-1];
    s_on = 1;
  endtask

  always @(sclk) begin
    tog++;
    if (s_on && cs_pin == 1'b0 && sclk == (s_cpol == s_cpha)) begin
      s_rx = {s_rx[14:0], mosi};
      s_idx++;
      if (s_idx == s_n) begin
        s_words++;
        if (mon_on) begin
          if (exp_q.size() == 0) check("R3 mosi word unexpected", {16'h0, s_rx}, 32'hFFFF_FFFF);
          else check("R3 mosi word", {16'h0, s_rx}, {16'h0, exp_q.pop_front()});
        end
        s_tx = (resp_q.size() > 0) ? resp_q.pop_front() : 16'h0;
        s_idx = 0;
        s_rx = '0;
      end
      miso = s_tx[s_n-1-s_idx];
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d, input bit pop);
    @(negedge clk); bus_addr = a; bus_rd = pop;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic poll(input int bitpos, input string req);
    logic [31:0] s;
    for (int i = 0; i < 40000; i++) begin
      rd(3'd1, s, 0);
      if (s[bitpos]) return;
    end
    check({req, " poll timeout"}, 32'h0, 32'h1);
  endtask

  function automatic logic [31:0] mk(bit pha, bit pol, int dv, bit ep, int wl, logic [1:0] trm, bit frc);
    return (32'(frc) << 20) | (32'(trm) << 12) | (32'(wl) << 7) | (32'(ep) << 6) |
           (32'(dv) << 2) | (32'(pol) << 1) | 32'(pha);
  endfunction

  task automatic tr_word(input logic [15:0] tx, input logic [15:0] rsp, input int n,
                         input bit pol, input bit pha, input int exp_per, input string req);
    logic [31:0] v;
    logic [15:0] m;
    realtime t0, t1;
    m = 16'((32'd1 << n) - 1);
    exp_q.push_back(tx & m);
    resp_q.push_back(rsp);
    mon_on = 1;
    slave_start(n, pol, pha);
    wr(3'd3, {16'h0, tx});
    if (exp_per > 0) begin
      @(posedge sclk); t0 = $realtime;
      @(posedge sclk); t1 = $realtime;
      check("R2 sclk period cycles", 32'(int'((t1 - t0) / 5.0)), 32'(exp_per));
    end
    poll(0, req);
    rd(3'd4, v, 1);
    check({req, " rx data"}, v, {16'h0, rsp & m});
    rd(3'd1, v, 0);
    check("R6 status after read", v, 32'h6);
    s_on = 0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        n_fail++; n_tests++;
        $display("FAIL watchdog expired actual=%0d expected=<190000", cyc);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] v;
    int t;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    rd(3'd0, v, 0); check("R1 conf default", v, 32'h3C0);
    rd(3'd1, v, 0); check("R1 status default", v, 32'h6);
    rd(3'd5, v, 0); check("R1 sys done", v, 32'h1);
    check("R1 sclk idle", {31'h0, sclk}, 32'h0);
    check("R1 cs inactive", {31'h0, cs_pin}, 32'h1);

    // R5 chip select polarity and hold
    wr(3'd0, mk(0, 0, 1, 0, 7, 2'b00, 1)); check("R5 active high forced", {31'h0, cs_pin}, 32'h1);
    wr(3'd0, mk(0, 0, 1, 0, 7, 2'b00, 0)); check("R5 active high released", {31'h0, cs_pin}, 32'h0);
    wr(3'd0, mk(0, 0, 1, 1, 7, 2'b00, 1)); check("R5 active low forced", {31'h0, cs_pin}, 32'h0);
    wr(3'd0, mk(0, 0, 1, 1, 7, 2'b00, 0)); check("R5 active low released", {31'h0, cs_pin}, 32'h1);

    // R3 all four modes
    for (int m = 0; m < 4; m++) begin
      wr(3'd0, mk(m[0], m[1], 1, 1, 7, 2'b00, 1));
      wr(3'd2, 32'h1);
      repeat (3) @(negedge clk);
      check("R3 idle level", {31'h0, sclk}, {31'h0, m[1]});
      tr_word(16'(8'hA5 ^ (m * 17)), 16'(8'h3C + m * 29), 8, m[1], m[0], 0, "R3 mode exchange");
      wr(3'd2, 32'h0);
      wr(3'd0, mk(0, 0, 1, 1, 7, 2'b00, 0));
    end

    // R11 back-to-back words with select held
    wr(3'd0, mk(0, 0, 0, 1, 7, 2'b00, 1));
    wr(3'd2, 32'h1);
    exp_q.push_back(16'h5A); exp_q.push_back(16'hF0);
    resp_q.push_back(16'h96); resp_q.push_back(16'h69);
    mon_on = 1;
    slave_start(8, 0, 0);
    wr(3'd3, 32'h5A);
    poll(1, "R11 tx empty");
    wr(3'd3, 32'hF0);
    poll(0, "R11 first word");
    rd(3'd4, v, 1); check("R11 first rx", v, 32'h96);
    check("R5 select held between words", {31'h0, cs_pin}, 32'h0);
    poll(0, "R11 second word");
    rd(3'd4, v, 1); check("R11 second rx", v, 32'h69);
    s_on = 0;
    wr(3'd2, 32'h0);

    // R4 16-bit word, R2 divisor 3
    wr(3'd0, mk(0, 0, 1, 1, 15, 2'b00, 1));
    wr(3'd2, 32'h1);
    tr_word(16'hBEEF, 16'h1234, 16, 0, 0, 0, "R4 16-bit word");
    wr(3'd0, mk(0, 0, 3, 1, 7, 2'b00, 1));
    tr_word(16'h81, 16'hC7, 8, 0, 0, 16, "R2 divisor 3");
    // R2/R4 clamps: divisor 15 -> 12, length code 1 -> 4 bits
    wr(3'd0, mk(0, 0, 15, 1, 1, 2'b00, 1));
    tr_word(16'h000A, 16'h0005, 4, 0, 0, 8192, "R4 min length clamp");
    wr(3'd2, 32'h0);

    // R8 transmit only
    wr(3'd0, mk(1, 0, 1, 1, 7, 2'b10, 1));
    wr(3'd2, 32'h1);
    exp_q.push_back(16'hC3); exp_q.push_back(16'h3C);
    mon_on = 1;
    slave_start(8, 0, 1);
    wr(3'd3, 32'hC3);
    poll(1, "R8 tx empty");
    wr(3'd3, 32'h3C);
    repeat (4) @(negedge clk);
    poll(2, "R8 end of transfer");
    repeat (4) @(negedge clk);
    rd(3'd1, v, 0); check("R8 no rx full", v, 32'h6);
    check("R8 both words seen", 32'(s_words), 32'd2);
    s_on = 0;
    wr(3'd2, 32'h0);

    // R9 receive only
    wr(3'd0, mk(0, 0, 1, 1, 7, 2'b01, 1));
    wr(3'd2, 32'h1);
    resp_q.push_back(16'h11); resp_q.push_back(16'h22); resp_q.push_back(16'h33);
    mon_on = 0;
    slave_start(8, 0, 0);
    wr(3'd3, 32'h0);
    poll(0, "R9 first word");
    repeat (200) @(negedge clk);
    check("R9 stalls while full", 32'(s_words), 32'd1);
    rd(3'd4, v, 1); check("R9 word 1", v, 32'h11);
    poll(0, "R9 second word");
    rd(3'd4, v, 1); check("R9 word 2", v, 32'h22);
    poll(0, "R9 third word");
    rd(3'd4, v, 1); check("R9 word 3", v, 32'h33);
    wr(3'd2, 32'h0);
    repeat (3) @(negedge clk);
    t = tog;
    repeat (40) @(negedge clk);
    check("R7 stop halts sclk", 32'(tog - t), 32'd0);
    check("R9 stopped mid word", 32'(s_words), 32'd3);
    s_on = 0;
    wr(3'd0, mk(0, 0, 1, 1, 7, 2'b00, 0));

    // R7 enable gates shifting
    wr(3'd0, mk(0, 0, 1, 1, 7, 2'b00, 1));
    t = tog;
    wr(3'd3, 32'h5A);
    repeat (100) @(negedge clk);
    check("R7 no sclk while disabled", 32'(tog - t), 32'd0);
    rd(3'd1, v, 0); check("R6 tx pending status", v, 32'h0);
    exp_q.push_back(16'h5A); resp_q.push_back(16'hE1);
    mon_on = 1;
    slave_start(8, 0, 0);
    wr(3'd2, 32'h1);
    poll(0, "R7 runs after enable");
    rd(3'd4, v, 1); check("R7 rx after enable", v, 32'hE1);
    rd(3'd1, v, 0); check("R6 rx full cleared", v, 32'h6);
    s_on = 0;

    // R10 soft reset
    wr(3'd0, mk(1, 1, 5, 0, 9, 2'b10, 1));
    wr(3'd5, 32'h1);
    rd(3'd5, v, 0); check("R10 done low during reset", v, 32'h0);
    repeat (6) @(negedge clk);
    rd(3'd5, v, 0); check("R10 done after reset", v, 32'h1);
    rd(3'd0, v, 0); check("R10 conf default", v, 32'h3C0);
    rd(3'd2, v, 0); check("R10 ctrl default", v, 32'h0);
    check("R10 scoreboard drained", 32'(exp_q.size()), 32'd0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule